// File: doc/BRIEF.md
# Task Pause Mailbox Wait Unit

This unit lets any of four hardware tasks park itself on a mailbox register until a scheduler task lets it go. When a task issues a pause, the unit puts a request value on the register-file write port, aimed at the register the task named. From the next cycle on, that task's instruction slot is stalled. The scheduler polls the mailbox register. When it sees a pending request, it releases the task by writing the register back to its release value. The unit watches the register-file write bus for that write.

Each issue selects one of two watch modes. In zero mode the request value is never zero, so a poller only needs a non-zero test. Writing zero to the mailbox releases the task, and any reply goes back in some other register. In high-bit mode the request value has its most significant bit set. Any write that clears that bit releases the task, so the lower bits can carry a return value in the same register. The unit never compares against a stored copy of the request value. Per task it keeps only the watched address, the mode bit and a two-state machine with the states IDLE and WAIT. The transitions are: IDLE to WAIT on an issue, WAIT to IDLE on a release write or a restart, and WAIT to WAIT on a fresh issue.

Top module: `task_pause_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, every task stall output and slot_stall are low.
- R2: In the cycle of an issue with iss_hibit=0, rf_we is high, rf_waddr equals iss_addr and rf_wdata equals iss_data; if iss_data is zero, rf_wdata is 1 instead, so the request value is never zero.
- R3: In the cycle of an issue with iss_hibit=1, rf_wdata equals iss_data with bit DW-1 (bit 31) forced to 1. rf_we is low in every cycle without an issue.
- R4: task_stall[t] goes high in the cycle after task t issues a pause. It stays high until a release or a restart for that task.
- R5: In zero mode, a snooped write of value zero to the watched address drops the stall in the next cycle. A non-zero write to that address, or a zero write to any other address, leaves the stall high.
- R6: In high-bit mode, a snooped write to the watched address with bit 31 clear drops the stall in the next cycle, whatever the lower bits hold. A write with bit 31 set leaves the stall high.
- R7: Tasks are independent. One release write frees every task waiting on that address in a mode it satisfies, and no other task.
- R8: If a task issues in the same cycle as a snooped write that would release it, the issue wins. The task waits on the newly issued address and mode.
- R9: restart[t] forces task_stall[t] low in that same cycle and returns the task to IDLE. It overrides an issue by that task in the same cycle.
- R10: slot_stall always equals task_stall[cur_task], where cur_task is the 2-bit id of the task holding the current issue slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | Pause issued this cycle |
| iss_task | input | 2 | Id of the issuing task |
| iss_addr | input | 9 | Mailbox register address |
| iss_data | input | 32 | Request value supplied by the task |
| iss_hibit | input | 1 | 1 selects high-bit watch mode, 0 selects zero mode |
| snp_we | input | 1 | Snooped register-file write enable |
| snp_addr | input | 9 | Snooped write address |
| snp_data | input | 32 | Snooped write data |
| restart | input | 4 | Per-task restart, clears the wait |
| cur_task | input | 2 | Task owning the current slot |
| rf_we | output | 1 | Request write enable |
| rf_waddr | output | 9 | Request write address |
| rf_wdata | output | 32 | Request write value |
| task_stall | output | 4 | Per-task stall |
| slot_stall | output | 1 | Stall of the current slot's task |

## Verification
The assertions assume that all inputs are known after reset. They also assume that the snooped write bus carries writes from other tasks and never the unit's own request write, so a release can only come from the scheduler side. The stimulus drives the pause write and the snooped bus as separate streams. It mostly issues for tasks that are idle, and it also deliberately re-issues for a waiting task, because the reference model defines that case as a re-arm. Directed sequences hit the same-cycle conflicts (issue against release, restart against issue), and a long mixed phase covers interleavings among all four tasks on a small address set.

// File: rtl/tpause_pkg.sv
package tpause_pkg;
    typedef enum logic {TS_IDLE = 1'b0, TS_WAIT = 1'b1} tslot_state_e;
    typedef enum logic {WM_ZERO = 1'b0, WM_HIBIT = 1'b1} wmode_e;
endpackage

// File: rtl/pause_req_fmt.sv
module pause_req_fmt #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data_i,
    input  logic          hibit_i,
    output logic [DW-1:0] req_o
);
    localparam logic [DW-1:0] ONE_V = DW'(1);
    localparam logic [DW-1:0] TOP_V = ONE_V << (DW - 1);

    always_comb begin
        if (hibit_i) begin
            req_o = data_i | TOP_V;
        end else if (data_i == '0) begin
            req_o = ONE_V;
        end else begin
            req_o = data_i;
        end
    end
endmodule

// File: rtl/pause_release_det.sv
module pause_release_det #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic            snp_we_i,
    input  logic [AW-1:0]   snp_addr_i,
    input  logic [DW-1:0]   snp_data_i,
    input  logic [AW-1:0]   watch_addr_i,
    input  tpause_pkg::wmode_e watch_mode_i,
    output logic            release_o
);
    import tpause_pkg::*;
    logic hit;
    logic cond;

    always_comb begin
        hit = snp_we_i && (snp_addr_i == watch_addr_i);
        unique case (watch_mode_i)
            WM_ZERO:  cond = (snp_data_i == '0);
            WM_HIBIT: cond = !snp_data_i[DW-1];
            default:  cond = 1'b0;
        endcase
        release_o = hit && cond;
    end
endmodule

// File: rtl/pause_task_slot.sv
module pause_task_slot #(
    parameter int AW    = 9,
    parameter int DW    = 32,
    parameter int TW    = 2,
    parameter int MY_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid_i,
    input  logic [TW-1:0] iss_task_i,
    input  logic [AW-1:0] iss_addr_i,
    input  logic          iss_hibit_i,
    input  logic          snp_we_i,
    input  logic [AW-1:0] snp_addr_i,
    input  logic [DW-1:0] snp_data_i,
    input  logic          restart_i,
    output logic          stall_o
);
    import tpause_pkg::*;
    localparam logic [TW-1:0] ID_V = TW'(MY_ID);

    tslot_state_e st_q, st_d;
    logic [AW-1:0] wa_q;
    wmode_e        wm_q;
    logic          issue_me;
    logic          rel;

    assign issue_me = iss_valid_i && (iss_task_i == ID_V);

    pause_release_det #(.AW(AW), .DW(DW)) u_det (
        .snp_we_i     (snp_we_i),
        .snp_addr_i   (snp_addr_i),
        .snp_data_i   (snp_data_i),
        .watch_addr_i (wa_q),
        .watch_mode_i (wm_q),
        .release_o    (rel)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: begin
                if (!restart_i && issue_me) st_d = TS_WAIT;
            end
            TS_WAIT: begin
                if (restart_i)     st_d = TS_IDLE;
                else if (issue_me) st_d = TS_WAIT;
                else if (rel)      st_d = TS_IDLE;
            end
            default: st_d = TS_IDLE;
        endcase
    end

    // state register and watch entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TS_IDLE;
            wa_q <= '0;
            wm_q <= WM_ZERO;
        end else begin
            st_q <= st_d;
            if (issue_me && !restart_i) begin
                wa_q <= iss_addr_i;
                wm_q <= iss_hibit_i ? WM_HIBIT : WM_ZERO;
            end
        end
    end

    // outputs
    always_comb begin
        stall_o = (st_q == TS_WAIT) && !restart_i;
    end
endmodule

// File: rtl/task_pause_unit.sv
module task_pause_unit #(
    parameter int NT = 4,
    parameter int AW = 9,
    parameter int DW = 32,
    localparam int TW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [TW-1:0] iss_task,
    input  logic [AW-1:0] iss_addr,
    input  logic [DW-1:0] iss_data,
    input  logic          iss_hibit,
    input  logic          snp_we,
    input  logic [AW-1:0] snp_addr,
    input  logic [DW-1:0] snp_data,
    input  logic [NT-1:0] restart,
    input  logic [TW-1:0] cur_task,
    output logic          rf_we,
    output logic [AW-1:0] rf_waddr,
    output logic [DW-1:0] rf_wdata,
    output logic [NT-1:0] task_stall,
    output logic          slot_stall
);
    pause_req_fmt #(.DW(DW)) u_fmt (
        .data_i  (iss_data),
        .hibit_i (iss_hibit),
        .req_o   (rf_wdata)
    );

    assign rf_we    = iss_valid;
    assign rf_waddr = iss_addr;

    for (genvar t = 0; t < NT; t++) begin : g_slot
        pause_task_slot #(.AW(AW), .DW(DW), .TW(TW), .MY_ID(t)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .iss_valid_i (iss_valid),
            .iss_task_i  (iss_task),
            .iss_addr_i  (iss_addr),
            .iss_hibit_i (iss_hibit),
            .snp_we_i    (snp_we),
            .snp_addr_i  (snp_addr),
            .snp_data_i  (snp_data),
            .restart_i   (restart[t]),
            .stall_o     (task_stall[t])
        );
    end

    assign slot_stall = task_stall[cur_task];
endmodule

// File: rtl/task_pause_chk.sv
module task_pause_chk #(
    parameter int NT = 4,
    parameter int AW = 9,
    parameter int DW = 32,
    localparam int TW = $clog2(NT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic [TW-1:0] iss_task,
    input logic [AW-1:0] iss_addr,
    input logic [DW-1:0] iss_data,
    input logic          iss_hibit,
    input logic          snp_we,
    input logic [AW-1:0] snp_addr,
    input logic [DW-1:0] snp_data,
    input logic [NT-1:0] restart,
    input logic [TW-1:0] cur_task,
    input logic          rf_we,
    input logic [AW-1:0] rf_waddr,
    input logic [DW-1:0] rf_wdata,
    input logic [NT-1:0] task_stall,
    input logic          slot_stall
);
    p_req_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata != '0));

    p_req_topbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && iss_hibit) |-> rf_wdata[DW-1]);

    p_slot_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stall |-> ($countones(task_stall) >= 1));

    for (genvar t = 0; t < NT; t++) begin : g_chk
        p_issue_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_task == TW'(t) && !restart[t]) |=> (task_stall[t] || restart[t]));

        p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (task_stall[t] && !snp_we) |=> (task_stall[t] || restart[t]));

        p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            restart[t] |-> !task_stall[t]);

        p_restart_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (restart[t] && !(iss_valid && iss_task == TW'(t))) |=> !task_stall[t] || restart[t] ||
            (iss_valid && iss_task == TW'(t)) || !$past(restart[t]));
    end
endmodule

bind task_pause_unit task_pause_chk #(.NT(NT), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_task_pause_unit.sv
module tb_task_pause_unit;
    localparam int NT = 4;
    localparam int AW = 9;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_task = '0;
    logic [AW-1:0] iss_addr = '0;
    logic [DW-1:0] iss_data = '0;
    logic          iss_hibit = 1'b0;
    logic          snp_we = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic [NT-1:0] restart = '0;
    logic [1:0]    cur_task = '0;
    logic          rf_we;
    logic [AW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;
    logic [NT-1:0] task_stall;
    logic          slot_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit  m_wait [NT];
    int  m_addr [NT];
    bit  m_hib  [NT];

    always #5 clk = ~clk;

    task_pause_unit #(.NT(NT), .AW(AW), .DW(DW)) dut (.*);

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] exp_stall();
        logic [NT-1:0] v;
        for (int t = 0; t < NT; t++) v[t] = m_wait[t] && !restart[t];
        return v;
    endfunction

    // compare outputs, take a clock, advance the model, clear pulses
    task automatic step(input string tag);
        logic [NT-1:0] es;
        logic [DW-1:0] ed;
        #1;
        chk(rf_we == iss_valid, iss_hibit ? "R3" : "R2", "rf_we", DW'(rf_we), DW'(iss_valid));
        if (iss_valid) begin
            if (iss_hibit) ed = iss_data | 32'h8000_0000;
            else if (iss_data == 0) ed = 32'd1;
            else ed = iss_data;
            chk(rf_waddr == iss_addr, "R2", "rf_waddr", DW'(rf_waddr), DW'(iss_addr));
            chk(rf_wdata == ed, iss_hibit ? "R3" : "R2", "rf_wdata", rf_wdata, ed);
        end
        es = exp_stall();
        chk(task_stall == es, tag, "task_stall", DW'(task_stall), DW'(es));
        chk(slot_stall == es[cur_task], "R10", "slot_stall", DW'(slot_stall), DW'(es[cur_task]));
        @(posedge clk);
        for (int t = 0; t < NT; t++) begin
            if (restart[t]) begin
                m_wait[t] = 0;
            end else if (iss_valid && iss_task == t) begin
                m_wait[t] = 1;
                m_addr[t] = iss_addr;
                m_hib[t]  = iss_hibit;
            end else if (m_wait[t] && snp_we && snp_addr == m_addr[t]) begin
                if (m_hib[t] ? !snp_data[31] : (snp_data == 0)) m_wait[t] = 0;
            end
        end
        @(negedge clk);
        iss_valid = 0;
        snp_we    = 0;
        restart   = '0;
        cur_task  = cur_task + 1'b1;
    endtask

    task automatic issue(input int t, input int a, input logic [31:0] d, input bit h);
        iss_valid = 1; iss_task = 2'(t); iss_addr = AW'(a); iss_data = d; iss_hibit = h;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        snp_we = 1; snp_addr = AW'(a); snp_data = d;
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin m_wait[t] = 0; m_addr[t] = 0; m_hib[t] = 0; end
        @(negedge clk);
        #1;
        chk(task_stall == '0, "R1", "stall in reset", DW'(task_stall), 0);
        chk(slot_stall == 0, "R1", "slot in reset", DW'(slot_stall), 0);
        @(negedge clk);
        rst_n = 1;
        step("R1");

        // R2 / R4 / R5: zero mode on task 0
        issue(0, 5, 32'h1234, 0); step("R4");
        step("R4"); step("R4");
        wr(5, 32'h7);   step("R5");   // non-zero: no release
        wr(6, 32'h0);   step("R5");   // other address: no release
        wr(5, 32'h0);   step("R5");   // release
        step("R5");

        // R2: zero data becomes 1
        issue(1, 3, 32'h0, 0); step("R2");
        wr(3, 32'h0); step("R5");

        // R3 / R6: high-bit mode on task 2
        issue(2, 7, 32'h55, 1); step("R3");
        wr(7, 32'h8000_0001); step("R6");
        wr(7, 32'h0000_0042); step("R6");
        step("R6");

        // R7: shared address
        issue(0, 9, 32'h1, 0); step("R7");
        issue(3, 9, 32'h2, 1); step("R7");
        issue(1, 10, 32'h3, 0); step("R7");
        wr(9, 32'h0); step("R7");
        step("R7");

        // R8: issue beats release for task 1
        issue(1, 11, 32'h9, 0); wr(10, 32'h0); step("R8");
        step("R8");
        wr(11, 32'h0); step("R8");

        // R9: restart while waiting, and restart against an issue
        issue(2, 12, 32'h4, 0); step("R9");
        restart = 4'b0100; step("R9");
        step("R9");
        issue(3, 13, 32'h4, 0); restart = 4'b1000; step("R9");
        step("R9");

        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom % 8;
            if (r < 3) issue($urandom % 4, 20 + ($urandom % 3), $urandom, bit'($urandom % 2));
            if (r >= 2 && r < 6) wr(20 + ($urandom % 3), ($urandom % 2) ? 32'h0 : $urandom);
            if (r == 7) restart = 4'($urandom);
            cur_task = 2'($urandom);
            step("R7");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule